// File: doc/BRIEF.md
# Fault and Interrupt Vector Generator

This block sits beside a microcoded sequencer and decides which pending exception is served next. Sixteen request lines arrive. Lines 1 to 7 carry synchronous faults as single-cycle pulses. Lines 8 to 15 carry interrupts. Every request is caught in a pending latch. A priority encoder selects the lowest-numbered eligible latch. Faults are always eligible. Interrupts are eligible only while the internal interrupt-enable flag is set. Line 0 is never served, so the word at the bottom of the table stays free for a short branch over the table.

When a request wins, the block gives the sequencer a one-cycle take strobe, the winning cause number and the address of its table entry. The address is a fixed base plus twice the cause, because every table slot is two bytes. The base is a compile-time parameter. It defaults to 0x0000 and can be set to another constant such as 0x7F00. The cause and the address stay frozen until the sequencer acknowledges. The acknowledge clears the served latch.

Control is a three-state machine. IDLE moves to STROBE (the "take" transition) when any request is eligible. STROBE moves back to IDLE (the "early acknowledge" transition) when acknowledge is present, and otherwise to HOLD (the "await" transition). HOLD moves to IDLE (the "release" transition) on acknowledge and stays in HOLD otherwise. Taking a trap clears interrupt-enable. Only an explicit enable pulse sets it again.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset no request is pending, the take strobe is low, the cause is 0 (so the address equals the base), and interrupt-enable is 0, so an interrupt request stays unserved until an enable pulse arrives.
- R2: The vector address equals VEC_BASE + 2 × cause. VEC_BASE is a parameter that defaults to 0x0000.
- R3: A request on line 0 never produces a take strobe, in any state of interrupt-enable.
- R4: Among eligible pending requests, the lowest line number wins.
- R5: A single-cycle pulse on a fault line (1 to 7) is latched and served whatever the state of interrupt-enable.
- R6: Interrupt lines (8 to 15) are served only while interrupt-enable is 1. A pulse on the enable input sets it at the next clock edge.
- R7: Taking any trap clears interrupt-enable, so a later interrupt waits for a new enable pulse.
- R8: The take strobe is high for exactly one cycle, in the cycle after the edge that latched the request. Cause and address stay stable from the strobe until the edge that samples acknowledge.
- R9: Acknowledge clears only the latch of the served cause. Acknowledge while nothing is outstanding has no effect.
- R10: If a request line is high at the edge that clears its latch, the request wins and the latch stays set.
- R11: No new trap is taken while one is outstanding. The next winner is strobed at the edge after the acknowledging edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ (16) | Request lines; bit i is cause i. Bits 1..7 are faults, bits 8..15 are interrupts, bit 0 is ignored |
| ie_set_i | input | 1 | Pulse that sets interrupt-enable |
| ack_i | input | 1 | Sequencer acknowledge of the outstanding trap |
| trap_o | output | 1 | One-cycle take-trap strobe |
| cause_o | output | IDX_W (4) | Index of the trap being served |
| vec_addr_o | output | ADDR_W (16) | Address of the vector table slot |

## Verification
A request driven before a clock edge is latched at that edge. The strobe, cause and address appear after the following edge, so results are due two edges after the stimulus. An enable pulse takes effect at the first edge. An acknowledge releases the machine at the first edge, and any further winner is strobed at the second. The bench drives inputs and samples outputs on the falling edge. It counts exactly these edges before each comparison, and it also checks that the strobe is still low one edge after the request. The vector table is run against a non-zero base so that the address check covers both the base and the doubled index.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2
    } trap_state_e;

endpackage

// File: rtl/trap_pending.sv
module trap_pending #(
    parameter int NUM_REQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] set_i,
    input  logic [NUM_REQ-1:0] clr_i,
    output logic [NUM_REQ-1:0] pend_o
);

    logic [NUM_REQ-1:0] pend_q;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
            if (g == 0) begin : g_null
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pend_q[g] <= 1'b0;
                    else        pend_q[g] <= 1'b0;
                end
            end else begin : g_latch
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)         pend_q[g] <= 1'b0;
                    else if (set_i[g])  pend_q[g] <= 1'b1;
                    else if (clr_i[g])  pend_q[g] <= 1'b0;
                end

                // R9
                clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_i[g] && !set_i[g]) |=> !pend_q[g]);

                // R10
                set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    set_i[g] |=> pend_q[g]);
            end
        end
    endgenerate

    assign pend_o = pend_q;

endmodule

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
    parameter int NUM_REQ   = 16,
    parameter int FIRST_IRQ = 8,
    localparam int IDX_W    = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] pend_i,
    input  logic               ie_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [NUM_REQ-1:0] elig;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_gate
            if (g == 0) begin : g_never
                assign elig[g] = 1'b0;
            end else if (g < FIRST_IRQ) begin : g_fault
                assign elig[g] = pend_i[g];
            end else begin : g_irq
                assign elig[g] = pend_i[g] & ie_i;
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = NUM_REQ - 1; i >= 1; i--) begin
            if (elig[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |elig;

    // R3
    no_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (idx_o != '0));

    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_o && (int'(idx_o) >= FIRST_IRQ)) |-> ie_i);

    // R4
    winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_i[idx_o]);

endmodule

// File: rtl/trap_vec_addr.sv
module trap_vec_addr #(
    parameter int          IDX_W    = 4,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_BASE = 16'h0000
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);

    assign addr_o = BASE + (ADDR_W'(idx_i) << 1);

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit #(
    parameter int          NUM_REQ   = 16,
    parameter int          FIRST_IRQ = 8,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] VEC_BASE  = 16'h0000,
    localparam int         IDX_W     = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               ie_set_i,
    input  logic               ack_i,
    output logic               trap_o,
    output logic [IDX_W-1:0]   cause_o,
    output logic [ADDR_W-1:0]  vec_addr_o
);

    import trap_pkg::*;

    trap_state_e        state_q, state_d;
    logic [IDX_W-1:0]   cause_q;
    logic               ie_q;
    logic [NUM_REQ-1:0] pend;
    logic [NUM_REQ-1:0] clr;
    logic               any_elig;
    logic [IDX_W-1:0]   win_idx;
    logic               take;
    logic               busy;

    assign busy = (state_q != ST_IDLE);
    assign take = (state_q == ST_IDLE) && any_elig;
    assign clr  = (busy && ack_i) ? (NUM_REQ'(1) << cause_q) : '0;

    trap_pending #(.NUM_REQ(NUM_REQ)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    trap_prio_enc #(.NUM_REQ(NUM_REQ), .FIRST_IRQ(FIRST_IRQ)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .ie_i   (ie_q),
        .any_o  (any_elig),
        .idx_o  (win_idx)
    );

    trap_vec_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_addr (
        .idx_i  (cause_q),
        .addr_o (vec_addr_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) cause_q <= win_idx;
            if (take)          ie_q <= 1'b0;
            else if (ie_set_i) ie_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_elig) state_d = ST_STROBE;
            ST_STROBE: state_d = ack_i ? ST_IDLE : ST_HOLD;
            ST_HOLD:   if (ack_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trap_o  = (state_q == ST_STROBE);
        cause_o = cause_q;
    end

    // R8
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // R8
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack_i) |=> ($stable(cause_o) && $stable(vec_addr_o)));

    // R7
    ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> !ie_q);

    // R11
    no_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack_i) |=> !trap_o);

endmodule

// File: tb/trap_vector_unit_test.sv
module trap_vector_unit_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] BASE       = 16'h7F00;
    localparam int          NV         = 10;

    localparam logic [15:0] TV_REQ [NV] = '{
        16'h0002, 16'h0080, 16'h0100, 16'h8000, 16'h00A4,
        16'h0300, 16'h0F10, 16'hFF00, 16'h0001, 16'hC040 };
    localparam bit TV_IE [NV] = '{ 0, 0, 1, 1, 0, 1, 1, 0, 1, 1 };
    localparam int TV_EXP [NV] = '{ 1, 7, 8, 15, 2, 8, 4, 0, 0, 6 };

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] req_i = '0;
    logic        ie_set_i = 0;
    logic        ack_i = 0;
    logic        trap_o;
    logic [3:0]  cause_o;
    logic [15:0] vec_addr_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_vector_unit #(.VEC_BASE(BASE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .ie_set_i   (ie_set_i),
        .ack_i      (ack_i),
        .trap_o     (trap_o),
        .cause_o    (cause_o),
        .vec_addr_o (vec_addr_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_trap(input int exp, input string tag);
        chk(trap_o == 1'b1, {tag, " strobe"}, int'(trap_o), 1);
        chk(int'(cause_o) == exp, {tag, " cause"}, int'(cause_o), exp);
        chk(int'(vec_addr_o) == int'(BASE) + 2 * exp, {tag, " R2 address"},
            int'(vec_addr_o), int'(BASE) + 2 * exp);
    endtask

    task automatic do_ack();
        ack_i = 1; tick(); ack_i = 0;
    endtask

    // serve everything left, then leave interrupt-enable cleared via a fault
    task automatic drain_clear();
        for (int k = 0; k < 30; k++) begin
            ack_i = trap_o; ie_set_i = 1; tick();
        end
        ack_i = 0; ie_set_i = 0;
        tick();
        req_i = 16'h0080; tick(); req_i = '0; tick();
        do_ack();
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(trap_o == 0, "R1 strobe after reset", int'(trap_o), 0);
        chk(vec_addr_o == BASE, "R1 address after reset", int'(vec_addr_o), int'(BASE));

        // R1: interrupt waits for enable; latch holds it
        req_i = 16'h0200; tick(); req_i = '0;
        for (int k = 0; k < 4; k++) begin
            chk(trap_o == 0, "R1 irq blocked at reset", int'(trap_o), 0);
            tick();
        end
        ie_set_i = 1; tick(); ie_set_i = 0; tick();
        chk_trap(9, "R6 irq after enable");
        do_ack();

        // R3: line 0 never served
        req_i = 16'h0001; ie_set_i = 1; tick(); req_i = '0; ie_set_i = 0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(trap_o == 0, "R3 line zero", int'(trap_o), 0);
        end
        drain_clear();

        // R4 R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            req_i = TV_REQ[v]; ie_set_i = TV_IE[v]; tick();
            req_i = '0; ie_set_i = 0;
            chk(trap_o == 0, "R8 no strobe one edge after request", int'(trap_o), 0);
            tick();
            if (TV_EXP[v] != 0) begin
                chk_trap(TV_EXP[v], "R4 table winner");
                do_ack();
            end else begin
                chk(trap_o == 0, "R6 table nothing eligible", int'(trap_o), 0);
            end
            drain_clear();
        end

        // R7: taking a fault clears enable
        ie_set_i = 1; req_i = 16'h0004; tick(); ie_set_i = 0; req_i = '0; tick();
        chk_trap(2, "R5 fault with enable");
        do_ack();
        req_i = 16'h0400; tick(); req_i = '0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(trap_o == 0, "R7 enable cleared by take", int'(trap_o), 0);
        end
        ie_set_i = 1; tick(); ie_set_i = 0; tick();
        chk_trap(10, "R7 irq after re-enable");
        do_ack();

        // R8 R11: hold while outstanding, higher fault waits
        req_i = 16'h0008; tick(); req_i = '0; tick();
        chk_trap(3, "R8 first trap");
        req_i = 16'h0002; tick(); req_i = '0;
        chk(trap_o == 0, "R8 single-cycle strobe", int'(trap_o), 0);
        chk(cause_o == 3, "R8 cause held", int'(cause_o), 3);
        chk(int'(vec_addr_o) == int'(BASE) + 6, "R8 address held", int'(vec_addr_o), int'(BASE) + 6);
        tick();
        chk(trap_o == 0, "R11 no nested take", int'(trap_o), 0);
        chk(cause_o == 3, "R11 cause still held", int'(cause_o), 3);
        do_ack(); tick();
        chk_trap(1, "R11 next winner after ack");
        do_ack();

        // R9: ack with nothing outstanding is ignored
        req_i = 16'h1000; tick(); req_i = '0;
        ack_i = 1; tick(); ack_i = 0; tick();
        chk(trap_o == 0, "R9 idle ack no strobe", int'(trap_o), 0);
        ie_set_i = 1; tick(); ie_set_i = 0; tick();
        chk_trap(12, "R9 latch survives idle ack");
        do_ack();

        // R10: level request held through ack stays pending
        ie_set_i = 1; req_i = 16'h0800; tick(); ie_set_i = 0; tick();
        chk_trap(11, "R10 level irq");
        do_ack(); req_i = '0; tick();
        chk(trap_o == 0, "R10 enable cleared", int'(trap_o), 0);
        ie_set_i = 1; tick(); ie_set_i = 0; tick();
        chk_trap(11, "R10 re-pended by held level");
        do_ack();
        drain_clear();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule